// File: doc/BRIEF.md
# Double-Precision to Signed 64-bit Integer Converter

This block turns a 64-bit binary floating-point operand into a two's-complement 64-bit integer, rounding in one of four selectable directions. It sorts the operand into a class (zero, subnormal, normal, infinity, quiet NaN or signaling NaN). It then aligns the significand against the binary point with a left or right shift, keeping a guard bit and a sticky bit. Next it rounds the magnitude and applies the sign. Three flags go with every result: invalid, integer overflow and inexact.

The datapath is a single combinational pass. It is followed by one output register with a valid/ready handshake. An operand is taken when `in_valid` and `in_ready` are both high, and its result is presented on the next cycle. That result stays in place until the consumer takes it. Back-to-back operands move at one per cycle while `out_ready` stays high.

Top module: `f64_to_i64_cvt`

## Requirements
- R1: An operand whose exponent field is all ones is an infinity when its fraction is zero and a signaling NaN when its fraction is nonzero with fraction bit 51 clear. Either one gives a result of 0 with the invalid flag set and the other two flags clear.
- R2: An operand whose exponent field is all ones with fraction bit 51 set is a quiet NaN. It gives a result of 0 with no flag set.
- R3: A zero of either sign gives 0 with no flag. A subnormal operand (exponent field zero, fraction nonzero) is treated as a magnitude below one: it gives 0, +1 or -1 according to the rounding mode, with inexact set.
- R4: An operand with magnitude of at least 2^63 (unbiased exponent 63 or more) sets both the integer-overflow and inexact flags. The result is the low 64 bits of the significand shifted left by (unbiased exponent - 52), negated when the sign bit is 1, with no saturation.
- R5: Rounding mode 2'b00 rounds to nearest, and a tie goes to the even integer.
- R6: Rounding mode 2'b01 rounds toward zero.
- R7: Rounding mode 2'b10 rounds toward minus infinity, giving the floor.
- R8: Rounding mode 2'b11 rounds toward plus infinity, giving the ceiling.
- R9: For a finite operand of magnitude below 2^63, inexact is set exactly when the operand is not an integer, and invalid and integer-overflow are clear.
- R10: `in_ready` is high whenever the output register is empty or is being drained. A result appears with `out_valid` on the cycle after its operand is accepted. A result that is not taken stays unchanged, with `out_valid` held high.
- R11: While reset is asserted and after it is released, `out_valid` is low until an operand is accepted.
- R12: The invalid flag is never set together with integer overflow or inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Converter can take an operand this cycle |
| in_op | input | 64 | Double-precision operand |
| in_rm | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 down, 11 up |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_valid | output | 1 | Result register holds a result |
| out_int | output | 64 | Two's-complement integer result |
| out_inv | output | 1 | Invalid operation flag |
| out_ovf | output | 1 | Integer overflow flag |
| out_inex | output | 1 | Inexact flag |

## Verification
Taking a new operand and handing over the previous result can happen in the same clock edge. This occurs when the output register is full, `out_ready` is high and `in_valid` is high. The bench provokes it by randomising both `in_valid` and `out_ready` each cycle, so that stalls, drains and simultaneous load-and-drain all appear. Results are judged against an in-order queue of expected values that the bench computes from each accepted operand. A lost, repeated or reordered result shows as a miscompare, and a stalled result is compared against its value on the previous cycle.

// File: rtl/f64cvt_pkg.sv
package f64cvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } fclass_e;

endpackage

// File: rtl/f64_unpack.sv
module f64_unpack
  import f64cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int FP_W  = EXP_W + FRAC_W + 1,
  localparam int EW    = EXP_W + 2
) (
  input  logic [FP_W-1:0]      op,
  output logic                 sgn,
  output fclass_e              cls,
  output logic [FRAC_W:0]      sig,
  output logic signed [EW-1:0] uexp
);

  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
  localparam logic signed [EW-1:0] MIN_S  = EW'(1 - BIAS);

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;
  logic              e_ones;
  logic              e_zero;
  logic              f_zero;

  always_comb begin
    sgn    = op[FP_W-1];
    efield = op[FP_W-2 -: EXP_W];
    ffield = op[FRAC_W-1:0];
    e_ones = &efield;
    e_zero = ~|efield;
    f_zero = ~|ffield;
    sig    = {~e_zero, ffield};
    uexp   = e_zero ? MIN_S : ($signed({2'b00, efield}) - BIAS_S);
    if (e_ones) begin
      if (f_zero)                  cls = CL_INF;
      else if (ffield[FRAC_W-1])   cls = CL_QNAN;
      else                         cls = CL_SNAN;
    end else if (e_zero) begin
      cls = f_zero ? CL_ZERO : CL_SUB;
    end else begin
      cls = CL_NORM;
    end
  end

endmodule

// File: rtl/f64_align.sv
module f64_align #(
  parameter int SIG_W = 53,
  parameter int INT_W = 64,
  parameter int EW    = 13
) (
  input  logic [SIG_W-1:0]     sig,
  input  logic signed [EW-1:0] uexp,
  output logic [INT_W-1:0]     mag,
  output logic                 guard,
  output logic                 sticky,
  output logic                 too_big
);

  localparam int FRAC_W = SIG_W - 1;
  localparam int SH_W   = $clog2(INT_W) + 1;
  localparam int WIDE   = 2 * INT_W;
  localparam logic signed [EW-1:0] FRAC_S = EW'(FRAC_W);
  localparam logic signed [EW-1:0] TOP_S  = EW'(INT_W - 1);
  localparam logic signed [EW-1:0] LIM_S  = EW'(INT_W);

  logic signed [EW-1:0] lsh_raw;
  logic signed [EW-1:0] rsh_raw;
  logic                 go_left;
  logic [SH_W-1:0]      sh;
  logic [INT_W-1:0]     shl_v;
  logic [WIDE-1:0]      base;
  logic [WIDE-1:0]      shr_v;

  always_comb begin
    lsh_raw = uexp - FRAC_S;
    rsh_raw = FRAC_S - uexp;
    go_left = (uexp >= FRAC_S);
    if (go_left) sh = (lsh_raw > LIM_S) ? SH_W'(INT_W) : lsh_raw[SH_W-1:0];
    else         sh = (rsh_raw > LIM_S) ? SH_W'(INT_W) : rsh_raw[SH_W-1:0];
    shl_v   = {{(INT_W-SIG_W){1'b0}}, sig} << sh;
    base    = {{(INT_W-SIG_W){1'b0}}, sig, {INT_W{1'b0}}};
    shr_v   = base >> sh;
    mag     = go_left ? shl_v : shr_v[WIDE-1:INT_W];
    guard   = go_left ? 1'b0 : shr_v[INT_W-1];
    sticky  = go_left ? 1'b0 : (|shr_v[INT_W-2:0]);
    too_big = (uexp >= TOP_S);
  end

endmodule

// File: rtl/i64_round.sv
module i64_round
  import f64cvt_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  fclass_e          cls,
  input  rmode_e           rm,
  input  logic             sgn,
  input  logic [INT_W-1:0] mag,
  input  logic             guard,
  input  logic             sticky,
  input  logic             too_big,
  output logic [INT_W-1:0] res,
  output logic             f_inv,
  output logic             f_ovf,
  output logic             f_inex
);

  logic             lost;
  logic             bump;
  logic [INT_W-1:0] mag_r;

  always_comb begin
    lost = guard | sticky;
    unique case (rm)
      RM_NEAR: bump = guard & (sticky | mag[0]);
      RM_ZERO: bump = 1'b0;
      RM_DOWN: bump = lost & sgn;
      RM_UP:   bump = lost & ~sgn;
      default: bump = 1'b0;
    endcase
    mag_r  = mag + INT_W'(bump);
    res    = '0;
    f_inv  = 1'b0;
    f_ovf  = 1'b0;
    f_inex = 1'b0;
    unique case (cls)
      CL_INF, CL_SNAN: f_inv = 1'b1;
      CL_QNAN, CL_ZERO: ;
      default: begin
        if (too_big) begin
          res    = sgn ? (~mag + 1'b1) : mag;
          f_ovf  = 1'b1;
          f_inex = 1'b1;
        end else begin
          res    = sgn ? (~mag_r + 1'b1) : mag_r;
          f_inex = lost;
        end
      end
    endcase
  end

endmodule

// File: rtl/f64_to_i64_cvt.sv
module f64_to_i64_cvt
  import f64cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int FP_W  = EXP_W + FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_op,
  input  logic [1:0]       in_rm,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [INT_W-1:0] out_int,
  output logic             out_inv,
  output logic             out_ovf,
  output logic             out_inex
);

  localparam int SIG_W = FRAC_W + 1;
  localparam int EW    = EXP_W + 2;

  logic                 u_sgn;
  fclass_e              u_cls;
  logic [SIG_W-1:0]     u_sig;
  logic signed [EW-1:0] u_exp;
  logic [INT_W-1:0]     a_mag;
  logic                 a_guard;
  logic                 a_sticky;
  logic                 a_big;
  logic [INT_W-1:0]     r_val;
  logic                 r_inv;
  logic                 r_ovf;
  logic                 r_inex;

  logic                 take;
  logic                 vld_d;
  logic                 vld_q;
  logic [INT_W-1:0]     int_q;
  logic                 inv_q;
  logic                 ovf_q;
  logic                 inex_q;

  f64_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_i (
    .op   (in_op),
    .sgn  (u_sgn),
    .cls  (u_cls),
    .sig  (u_sig),
    .uexp (u_exp)
  );

  f64_align #(.SIG_W(SIG_W), .INT_W(INT_W), .EW(EW)) align_i (
    .sig     (u_sig),
    .uexp    (u_exp),
    .mag     (a_mag),
    .guard   (a_guard),
    .sticky  (a_sticky),
    .too_big (a_big)
  );

  i64_round #(.INT_W(INT_W)) round_i (
    .cls     (u_cls),
    .rm      (rmode_e'(in_rm)),
    .sgn     (u_sgn),
    .mag     (a_mag),
    .guard   (a_guard),
    .sticky  (a_sticky),
    .too_big (a_big),
    .res     (r_val),
    .f_inv   (r_inv),
    .f_ovf   (r_ovf),
    .f_inex  (r_inex)
  );

  always_comb begin
    in_ready = ~vld_q | out_ready;
    take     = in_valid & in_ready;
    vld_d    = take | (vld_q & ~out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      int_q  <= r_val;
      inv_q  <= r_inv;
      ovf_q  <= r_ovf;
      inex_q <= r_inex;
    end
  end

  assign out_valid = vld_q;
  assign out_int   = int_q;
  assign out_inv   = inv_q;
  assign out_ovf   = ovf_q;
  assign out_inex  = inex_q;

endmodule

// File: rtl/f64_to_i64_cvt_chk.sv
module f64_to_i64_cvt_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int FP_W  = EXP_W + FRAC_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FP_W-1:0]  in_op,
  input logic [1:0]       in_rm,
  input logic             out_ready,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_inv,
  input logic             out_ovf,
  input logic             out_inex
);

  logic op_bad;
  assign op_bad = (&in_op[FP_W-2 -: EXP_W]) & ~in_op[FRAC_W-1];

  // R1
  bad_operand_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_bad) |=> (out_valid && out_inv && out_int == '0));

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int) && $stable(out_inv)
                                   && $stable(out_ovf) && $stable(out_inex)));

  // R4
  ovf_implies_inex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> out_inex);

  // R12
  inv_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |-> (!out_ovf && !out_inex && out_int == '0));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  logic unused_ok;
  assign unused_ok = ^in_rm;

endmodule

bind f64_to_i64_cvt f64_to_i64_cvt_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) chk_i (.*);

// File: tb/f64_to_i64_cvt_tb_top.sv
module f64_to_i64_cvt_tb_top;

  localparam int NRAND  = 3000;
  localparam int NDIR   = 22;
  localparam int MAXCYC = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_op;
  logic [1:0]  in_rm;
  logic        out_ready;
  logic        out_valid;
  logic [63:0] out_int;
  logic        out_inv;
  logic        out_ovf;
  logic        out_inex;

  int n_chk;
  int n_bad;

  f64_to_i64_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rm(in_rm), .out_ready(out_ready), .out_valid(out_valid),
    .out_int(out_int), .out_inv(out_inv), .out_ovf(out_ovf), .out_inex(out_inex)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bit [65:0] dir_vec [NDIR];
  bit [63:0] q_op [$];
  bit [1:0]  q_rm [$];

  task automatic check(input bit ok, input string tag, input bit [66:0] act, input bit [66:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built on real arithmetic for finite in-range operands.
  task automatic ref_conv(input bit [63:0] op, input bit [1:0] rm, output bit [63:0] r,
                          output bit inv, output bit ovf, output bit inex, output string tag);
    bit [10:0] e;
    bit [51:0] f;
    real x, fl, ce, d;
    longint lf, lc;
    int sh;
    bit [63:0] low;
    e = op[62:52]; f = op[51:0];
    r = '0; inv = 0; ovf = 0; inex = 0;
    if (e == 11'h7ff) begin
      if (f == 0 || !f[51]) begin inv = 1; tag = "R1"; end
      else tag = "R2";
    end else if (int'(e) >= 1023 + 63) begin
      sh = int'(e) - 1075;
      low = (sh > 63) ? 64'd0 : ({11'd0, 1'b1, f} << sh);
      r = op[63] ? (~low + 64'd1) : low;
      ovf = 1; inex = 1; tag = "R4";
    end else begin
      x = $bitstoreal(op);
      fl = $floor(x); ce = $ceil(x);
      lf = longint'(fl); lc = longint'(ce);
      inex = (fl != x);
      case (rm)
        2'b00: begin
          d = x - fl;
          if (d < 0.5) r = 64'(lf);
          else if (d > 0.5) r = 64'(lc);
          else r = lf[0] ? 64'(lc) : 64'(lf);
          tag = "R5";
        end
        2'b01: begin r = (x < 0.0) ? 64'(lc) : 64'(lf); tag = "R6"; end
        2'b10: begin r = 64'(lf); tag = "R7"; end
        default: begin r = 64'(lc); tag = "R8"; end
      endcase
      if (e == 0) tag = "R3";
    end
  endtask

  task automatic gen(input int idx, output bit [63:0] op, output bit [1:0] rm);
    int sel;
    bit [51:0] fr;
    bit [10:0] ex;
    if (idx < NDIR) begin
      {rm, op} = dir_vec[idx];
    end else begin
      sel = int'($urandom % 16);
      fr  = {$urandom, $urandom};
      if ($urandom % 4 == 0) fr[47:0] = '0;
      ex  = 11'(1015 + int'($urandom % 80));
      rm  = 2'($urandom);
      if (sel == 0)      op = {$urandom, $urandom};
      else if (sel == 1) op = {1'($urandom), 11'd0, fr};
      else               op = {1'($urandom), ex, fr};
    end
  endtask

  initial begin
    bit [63:0] cur_op, exp_r, hold_int, pop_op;
    bit [1:0]  cur_rm, pop_rm;
    bit        have, e_inv, e_ovf, e_inex, was_stall;
    bit [2:0]  hold_fl;
    string     tag;
    int        sent;
    int        total;
    void'($urandom(32'h5eed1234));
    n_chk = 0; n_bad = 0;
    dir_vec = '{
      {2'b00, 64'h7FF0000000000000}, {2'b01, 64'hFFF0000000000000},
      {2'b00, 64'h7FF0000000000001}, {2'b11, 64'h7FF8000000000000},
      {2'b00, 64'h0000000000000000}, {2'b10, 64'h8000000000000000},
      {2'b11, 64'h0000000000000001}, {2'b10, 64'h800000000000000F},
      {2'b00, 64'h0000000000000001}, {2'b00, 64'h4004000000000000},
      {2'b00, 64'h400C000000000000}, {2'b00, 64'hC004000000000000},
      {2'b00, 64'h3FE0000000000000}, {2'b00, 64'h3FF8000000000000},
      {2'b00, 64'h3FE8000000000000}, {2'b10, 64'hC004000000000000},
      {2'b11, 64'h4004000000000000}, {2'b01, 64'hC004000000000000},
      {2'b00, 64'h43E0000000000000}, {2'b01, 64'hC3E0000000000000},
      {2'b11, 64'h43DFFFFFFFFFFFFF}, {2'b00, 64'h7E00000000000000}
    };
    total = NDIR + NRAND;
    rst_n = 0; in_valid = 0; in_op = '0; in_rm = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    // R11: output empty while in reset
    check(out_valid == 1'b0, "R11", 67'(out_valid), 67'd0);
    rst_n = 1;
    @(negedge clk);
    // R11 and R10: empty after release, ready offered
    check(out_valid == 1'b0, "R11", 67'(out_valid), 67'd0);
    check(in_ready == 1'b1, "R10", 67'(in_ready), 67'd1);

    have = 0; sent = 0; was_stall = 0; hold_int = '0; hold_fl = '0;
    for (int cyc = 0; cyc < MAXCYC && (sent < total || q_op.size() > 0); cyc++) begin
      @(negedge clk);
      if (!have && sent < total && ($urandom % 4 != 0)) begin
        gen(sent, cur_op, cur_rm);
        have = 1;
      end
      in_valid  = have;
      in_op     = cur_op;
      in_rm     = cur_rm;
      out_ready = (sent < NDIR) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      if (was_stall) begin
        // R10: untaken result held
        check(out_valid && out_int == hold_int && {out_inv, out_ovf, out_inex} == hold_fl,
              "R10", {out_valid, out_int, 1'b0, out_inv, out_ovf},
              {1'b1, hold_int, 1'b0, hold_fl[2:1]});
      end
      was_stall = out_valid && !out_ready;
      hold_int  = out_int;
      hold_fl   = {out_inv, out_ovf, out_inex};
      if (out_valid && out_ready) begin
        if (q_op.size() == 0) begin
          check(1'b0, "R10", 67'(out_int), 67'd0);
        end else begin
          pop_op = q_op.pop_front();
          pop_rm = q_rm.pop_front();
          ref_conv(pop_op, pop_rm, exp_r, e_inv, e_ovf, e_inex, tag);
          check(out_int == exp_r, tag, {3'b0, out_int}, {3'b0, exp_r});
          if (tag == "R5" || tag == "R6" || tag == "R7" || tag == "R8") tag = "R9";
          check({out_inv, out_ovf, out_inex} == {e_inv, e_ovf, e_inex}, tag,
                67'({out_inv, out_ovf, out_inex}), 67'({e_inv, e_ovf, e_inex}));
          // R12
          check(!(out_inv && (out_ovf || out_inex)), "R12",
                67'({out_inv, out_ovf, out_inex}), 67'd0);
        end
      end
      if (in_valid && in_ready) begin
        q_op.push_back(cur_op);
        q_rm.push_back(cur_rm);
        sent++;
        have = 0;
      end
    end
    if (sent < total || q_op.size() > 0) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", sent, total);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule